// File: doc/BRIEF.md
# Retriggerable Ring Detect Interrupt Unit

This block turns per-sample threshold comparator strobes from a telephone line interface into a ring-detect status bit and a maskable level interrupt. A strobe from the positive comparator, or from the negative comparator when full-wave mode is selected, retriggers a one-shot. The one-shot counts a 1 ms tick input and holds the ring-detect bit high for a parameterised number of ticks after the last strobe. The block also presents registered copies of the two comparator strobes as raw status bits.

When validation is enabled, the ring-detect bit follows a validated-ring level from an external validation engine and the one-shot is bypassed. A line going off-hook forces the ring-detect bit low in either mode. A sticky interrupt flag is set on each rising edge of the ring-detect bit. In both-edges mode it is also set on the falling edge, which marks the end of a ring burst. Software clears the flag with a write strobe. The interrupt pin is the flag gated by a mask bit.

Top module: `ring_irq_unit`

## Requirements
- R1: After reset, every output (pos_stat, neg_stat, ring_det, irq_flag, irq_pin) is low.
- R2: pos_stat is high in the cycle after a cycle with pos_det high and low otherwise. neg_stat behaves the same way for neg_det.
- R3: In plain mode (val_en low) with full_wave low, only pos_det triggers ring_det, and a lone neg_det leaves ring_det low. With full_wave high, a neg_det strobe also sets ring_det in the next cycle.
- R4: In plain mode, a trigger sets ring_det in the next cycle and loads a count of HOLD_TICKS ticks. ring_det stays high through HOLD_TICKS-1 tick_1ms pulses and goes low on the pulse that completes HOLD_TICKS. A new trigger reloads the full count. A trigger in the same cycle as a tick reloads the count.
- R5: While off_hook is high, ring_det is low from the next cycle and triggers are ignored. The one-shot count is discarded, so ring_det stays low after off_hook drops.
- R6: irq_flag is set in the cycle in which ring_det rises. irq_pin is high only when irq_flag and irq_mask are both high.
- R7: A cycle with flag_clr high clears irq_flag in the next cycle. If a set edge occurs in the same cycle, the flag stays set.
- R8: With val_en high (and off_hook low), ring_det equals the val_ring value of the previous cycle, and detect strobes have no effect on it.
- R9: With edge_both high, a falling edge of ring_det also sets irq_flag. With edge_both low, a falling edge leaves irq_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond, clocks the one-shot |
| pos_det | input | 1 | Positive-threshold detect strobe |
| neg_det | input | 1 | Negative-threshold detect strobe |
| full_wave | input | 1 | 1: either polarity triggers; 0: positive only |
| off_hook | input | 1 | Line off-hook; forces ring_det low |
| irq_mask | input | 1 | 1 lets irq_flag drive irq_pin |
| edge_both | input | 1 | 1: flag also set on falling edge of ring_det |
| val_en | input | 1 | 1: ring_det follows val_ring |
| val_ring | input | 1 | Validated-ring level from the external engine |
| flag_clr | input | 1 | Software write strobe that clears irq_flag |
| pos_stat | output | 1 | Raw positive detect status |
| neg_stat | output | 1 | Raw negative detect status |
| ring_det | output | 1 | Ring-detect status bit |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_pin | output | 1 | Masked interrupt output |

## Verification
A wrong one-shot count shows at ring_det as an expiry that comes one or more ticks early or late after the last strobe. Because of this, the bench counts ticks exactly up to and across the terminal value, and across a reload. A broken edge detector or a broken set/clear priority shows on irq_flag in the same cycle as the ring_det change. The bench therefore samples the flag one cycle after each stimulus, including the case where a clear and a set arrive together. Off-hook and validation-mode faults show at ring_det one cycle after the controlling input changes. A count left behind by an off-hook would bring ring_det back high in the cycle after off_hook drops.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;

   typedef struct packed {
      logic pos;
      logic neg;
   } thr_pair_t;

   function automatic logic ring_trigger(thr_pair_t d, logic fw);
      return d.pos | (fw & d.neg);
   endfunction

endpackage

// File: rtl/ring_thr_status.sv
module ring_thr_status
   import ring_irq_pkg::*;
#(
   parameter bit REG_STATUS = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  thr_pair_t det,
   output thr_pair_t stat
);

   generate
      if (REG_STATUS) begin : g_reg
         thr_pair_t stat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= det;
         end
         assign stat = stat_q;
      end else begin : g_pass
         assign stat = det;
      end
   endgenerate

endmodule

// File: rtl/ring_oneshot.sv
module ring_oneshot #(
   parameter int HOLD_TICKS = 5000,
   localparam int CNT_W = $clog2(HOLD_TICKS + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   input  logic kill,
   output logic live_nxt
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (kill)
         cnt_d = '0;
      else if (trig)
         cnt_d = CNT_W'(HOLD_TICKS);
      else if (tick && (cnt_q != '0))
         cnt_d = cnt_q - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign live_nxt = (cnt_d != '0);

endmodule

// File: rtl/ring_irq_flag.sv
module ring_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic src_nxt,
   input  logic kill,
   input  logic edge_both,
   input  logic clr,
   input  logic mask,
   output logic ring_q,
   output logic flag_q,
   output logic pin
);

   logic ring_d;
   logic rise;
   logic fall;
   logic flag_d;

   assign ring_d = src_nxt & ~kill;
   assign rise   = ring_d & ~ring_q;
   assign fall   = ~ring_d & ring_q;

   always_comb begin
      flag_d = flag_q;
      if (rise || (edge_both && fall))
         flag_d = 1'b1;
      else if (clr)
         flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         ring_q <= ring_d;
         flag_q <= flag_d;
      end
   end

   assign pin = flag_q & mask;

endmodule

// File: rtl/ring_irq_unit.sv
module ring_irq_unit
   import ring_irq_pkg::*;
#(
   parameter int HOLD_TICKS = 5000,
   parameter bit REG_STATUS = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1ms,
   input  logic pos_det,
   input  logic neg_det,
   input  logic full_wave,
   input  logic off_hook,
   input  logic irq_mask,
   input  logic edge_both,
   input  logic val_en,
   input  logic val_ring,
   input  logic flag_clr,
   output logic pos_stat,
   output logic neg_stat,
   output logic ring_det,
   output logic irq_flag,
   output logic irq_pin
);

   initial begin
      if (HOLD_TICKS < 1) $error("HOLD_TICKS must be at least 1");
   end

   thr_pair_t det;
   thr_pair_t stat;
   logic      trig;
   logic      shot_nxt;
   logic      src_nxt;

   assign det.pos = pos_det;
   assign det.neg = neg_det;
   assign trig    = ring_trigger(det, full_wave);

   ring_thr_status #(.REG_STATUS(REG_STATUS)) u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .det  (det),
      .stat (stat)
   );

   ring_oneshot #(.HOLD_TICKS(HOLD_TICKS)) u_shot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1ms),
      .trig    (trig),
      .kill    (off_hook),
      .live_nxt(shot_nxt)
   );

   assign src_nxt = val_en ? val_ring : shot_nxt;

   ring_irq_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_nxt  (src_nxt),
      .kill     (off_hook),
      .edge_both(edge_both),
      .clr      (flag_clr),
      .mask     (irq_mask),
      .ring_q   (ring_det),
      .flag_q   (irq_flag),
      .pin      (irq_pin)
   );

   assign pos_stat = stat.pos;
   assign neg_stat = stat.neg;

endmodule

// File: rtl/ring_irq_unit_chk.sv
module ring_irq_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_1ms,
   input logic pos_det,
   input logic neg_det,
   input logic full_wave,
   input logic off_hook,
   input logic irq_mask,
   input logic edge_both,
   input logic val_en,
   input logic val_ring,
   input logic flag_clr,
   input logic pos_stat,
   input logic neg_stat,
   input logic ring_det,
   input logic irq_flag,
   input logic irq_pin
);

   AST_POS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) pos_det |=> pos_stat); // R2
   AST_FULLWAVE_NEG: assert property (@(posedge clk) disable iff (!rst_n) (!val_en && !off_hook && full_wave && neg_det) |=> ring_det); // R3
   AST_TRIGGER_SETS: assert property (@(posedge clk) disable iff (!rst_n) (!val_en && !off_hook && pos_det) |=> ring_det); // R4
   AST_OFFHOOK_KILL: assert property (@(posedge clk) disable iff (!rst_n) off_hook |=> !ring_det); // R5
   AST_RISE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(ring_det) |-> irq_flag); // R6
   AST_PIN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_pin |-> (irq_flag && irq_mask)); // R6
   AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_flag) |-> $past(flag_clr)); // R7
   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (val_en && !off_hook) |=> (ring_det == $past(val_ring))); // R8
   AST_FALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (edge_both && $fell(ring_det)) |-> irq_flag); // R9

endmodule

bind ring_irq_unit ring_irq_unit_chk u_chk (.*);

// File: tb/ring_irq_unit_tb.sv
module ring_irq_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1ms = 1'b0, pos_det = 1'b0, neg_det = 1'b0, full_wave = 1'b0;
   logic off_hook = 1'b0, irq_mask = 1'b0, edge_both = 1'b0, val_en = 1'b0;
   logic val_ring = 1'b0, flag_clr = 1'b0;
   logic pos_stat, neg_stat, ring_det, irq_flag, irq_pin;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_irq_unit #(.HOLD_TICKS(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pos_det(pos_det),
      .neg_det(neg_det), .full_wave(full_wave), .off_hook(off_hook),
      .irq_mask(irq_mask), .edge_both(edge_both), .val_en(val_en),
      .val_ring(val_ring), .flag_clr(flag_clr), .pos_stat(pos_stat),
      .neg_stat(neg_stat), .ring_det(ring_det), .irq_flag(irq_flag),
      .irq_pin(irq_pin)
   );

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {tick_1ms, pos_det, neg_det, full_wave, off_hook, irq_mask} = '0;
      {edge_both, val_en, val_ring, flag_clr} = '0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic pulse_pos();
      pos_det = 1'b1; cyc(1); pos_det = 1'b0;
   endtask

   task automatic pulse_neg();
      neg_det = 1'b1; cyc(1); neg_det = 1'b0;
   endtask

   task automatic ticks(int n);
      repeat (n) begin tick_1ms = 1'b1; cyc(1); tick_1ms = 1'b0; end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cyc(1);
      check("R1 pos_stat", pos_stat, 1'b0);
      check("R1 neg_stat", neg_stat, 1'b0);
      check("R1 ring_det", ring_det, 1'b0);
      check("R1 irq_flag", irq_flag, 1'b0);
      check("R1 irq_pin", irq_pin, 1'b0);
      do_reset();
   endtask

   task automatic t_status();
      do_reset();
      pulse_pos();
      check("R2 pos_stat set", pos_stat, 1'b1);
      check("R2 neg_stat quiet", neg_stat, 1'b0);
      cyc(1);
      check("R2 pos_stat low", pos_stat, 1'b0);
      pulse_neg();
      check("R2 neg_stat set", neg_stat, 1'b1);
      check("R2 pos_stat quiet", pos_stat, 1'b0);
   endtask

   task automatic t_wave();
      do_reset();
      pulse_neg();
      check("R3 half-wave neg ignored", ring_det, 1'b0);
      full_wave = 1'b1;
      pulse_neg();
      check("R3 full-wave neg triggers", ring_det, 1'b1);
   endtask

   task automatic t_oneshot();
      do_reset();
      pulse_pos();
      check("R4 trigger", ring_det, 1'b1);
      ticks(HOLD - 1);
      check("R4 held before terminal", ring_det, 1'b1);
      ticks(1);
      check("R4 expired at terminal", ring_det, 1'b0);
      pulse_pos();
      ticks(HOLD - 2);
      pulse_pos();
      ticks(HOLD - 1);
      check("R4 reload extends", ring_det, 1'b1);
      ticks(1);
      check("R4 reload expiry", ring_det, 1'b0);
      pos_det = 1'b1; tick_1ms = 1'b1; cyc(1); pos_det = 1'b0; tick_1ms = 1'b0;
      ticks(HOLD - 1);
      check("R4 trigger beats tick", ring_det, 1'b1);
   endtask

   task automatic t_offhook();
      do_reset();
      pulse_pos();
      off_hook = 1'b1;
      cyc(1);
      check("R5 off-hook clears", ring_det, 1'b0);
      pulse_pos();
      check("R5 trigger ignored", ring_det, 1'b0);
      off_hook = 1'b0;
      cyc(1);
      check("R5 count discarded", ring_det, 1'b0);
   endtask

   task automatic t_irq();
      do_reset();
      pulse_pos();
      check("R6 flag on rise", irq_flag, 1'b1);
      check("R6 pin masked", irq_pin, 1'b0);
      irq_mask = 1'b1;
      cyc(1);
      check("R6 pin unmasked", irq_pin, 1'b1);
   endtask

   task automatic t_clear();
      do_reset();
      irq_mask = 1'b1;
      pulse_pos();
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
      check("R7 clear", irq_flag, 1'b0);
      check("R7 pin follows", irq_pin, 1'b0);
      ticks(HOLD);
      check("R9 plain expiry", ring_det, 1'b0);
      check("R9 fall ignored without edge mode", irq_flag, 1'b0);
      pos_det = 1'b1; flag_clr = 1'b1; cyc(1); pos_det = 1'b0; flag_clr = 1'b0;
      check("R7 set wins over clear", irq_flag, 1'b1);
   endtask

   task automatic t_valid();
      do_reset();
      val_en = 1'b1;
      pulse_pos();
      check("R8 detect ignored", ring_det, 1'b0);
      check("R8 no flag", irq_flag, 1'b0);
      val_ring = 1'b1; cyc(1);
      check("R8 follows high", ring_det, 1'b1);
      check("R8 flag on rise", irq_flag, 1'b1);
      ticks(HOLD + 2);
      check("R8 no expiry", ring_det, 1'b1);
      val_ring = 1'b0; cyc(1);
      check("R8 follows low", ring_det, 1'b0);
   endtask

   task automatic t_edge();
      do_reset();
      val_en = 1'b1; edge_both = 1'b1;
      val_ring = 1'b1; cyc(1);
      check("R9 start flag", irq_flag, 1'b1);
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
      check("R9 cleared mid burst", irq_flag, 1'b0);
      val_ring = 1'b0; cyc(1);
      check("R9 end flag", irq_flag, 1'b1);
      check("R9 ring low", ring_det, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_status();
      t_wave();
      t_oneshot();
      t_offhook();
      t_irq();
      t_clear();
      t_valid();
      t_edge();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule